// File: doc/BRIEF.md
# Hot Swap Insertion and Extraction Controller

This block looks after one removable board on a bus that allows boards to be plugged in and pulled out while the system runs. It watches the ejector-handle switch, which bounces, and cleans it with a slow millisecond tick. It turns settled handle movements into two sticky events, "board seated" and "board leaving", and reports them to the host through an active-low open-drain enumeration interrupt. The interrupt stays pulled low until host software acknowledges each event by writing a one to its status bit.

The same 32-bit register word carries a read-only capability header and a control byte. The header holds a fixed identifier and a pointer to the next capability. Through the control byte software can mask the interrupt and drive a front-panel "safe to remove" LED. The LED output is also active-low open-drain. Hardware forces it on while bus reset is held, so the panel shows a safe state until the board's logic is running.

Top module: `hotswap_ctrl`

## Requirements
- R1: After reset the register word reads `{8'h00, 8'h00, ptr, 8'h06}`, where ptr is NEXT_PTR with bits 1:0 forced to 0. With the default NEXT_PTR of 4Fh, ptr reads 4Ch. The interrupt output is 1 (released).
- R2: `handle_sw` (1 = handle open) passes through a synchronizer and is sampled on each `ms_tick`. The debounced level changes only when six consecutive tick samples all differ from it. A run of fewer than six such samples, broken by one matching sample, causes no change and no event.
- R3: When the debounced handle goes from open to closed, the insertion flag (word bit 23, control bit 7) sets and `enum_pull_n` goes to 0.
- R4: When the debounced handle goes from closed to open, the removal flag (word bit 22, control bit 6) sets and `enum_pull_n` goes to 0.
- R5: Both flags are write-1-to-clear through byte lane 2 (`reg_be[2]`). A write with that lane disabled, or a write of 0 to a flag bit, leaves the flag unchanged. `enum_pull_n` stays 0 until every flag is clear.
- R6: Control bit 1 (word bit 17) is the interrupt mask. When it is 1, `enum_pull_n` is 1 even with flags pending, and the flags still read back. When it is 0, pending flags pull the interrupt low.
- R7: `led_pull_n` is 0 whenever control bit 3 (word bit 19) is 1 or `bus_rst_n` is 0. Otherwise it is 1.
- R8: Word bits 31:24, 21:20 (programming interface), 18, 16 and 9:8 always read 0. Writes to any lane other than lane 2, and to those control bits, have no effect.
- R9: While `bus_rst_n` is 0, the control byte is cleared and the debounced level is held at "handle open". A board that leaves bus reset with its handle closed therefore raises the insertion flag after six ticks.
- R10: `reg_rdata` captures the register word on the clock edge where `reg_rd` is 1, so data appears one cycle after the read request. Otherwise `reg_rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous to clk |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| handle_sw | input | 1 | Raw ejector switch, 1 = handle open |
| reg_rd | input | 1 | Read request for the register word |
| reg_wr | input | 1 | Write strobe for the register word |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| enum_pull_n | output | 1 | Enumeration interrupt, 0 = pull line low |
| led_pull_n | output | 1 | Status LED sink, 0 = LED lit |

## Verification
A stuck or mis-counting debounce counter shows up as an interrupt edge that arrives one tick early or late, or never. A five-tick bounce that leaves the interrupt released separates the two cases within a few milliseconds of ticks. A wrong flag or mask bit shows on `enum_pull_n` within one clock of the write that should have changed it, and in the control byte on the next read. The scoreboard compares every read word against the value expected from the events driven so far, so a corrupted header or control bit is caught on the first read that follows.

// File: rtl/hs_pkg.sv
// Shared constants for the hot swap controller.
// Assumes the control byte sits in lane 2 of the 32-bit register word.
package hs_pkg;
    localparam logic [7:0] HDR_ID      = 8'h06;
    localparam int         CTL_LANE    = 2;
    localparam int         CTL_INS_BIT = 7;
    localparam int         CTL_REM_BIT = 6;
    localparam int         CTL_LED_BIT = 3;
    localparam int         CTL_MSK_BIT = 1;

    typedef struct packed {
        logic ins;
        logic rem;
        logic led;
        logic msk;
    } hs_ctl_t;
endpackage

// File: rtl/hs_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 1; all flops reset to RST_VAL.
module hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= RST_VAL;
                else if (gi == 0) chain_q[gi] <= d;
                else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_debounce.sv
// Tick-sampled debouncer: the stable level flips only after SAMPLES
// consecutive ticks all see the opposite level.
// Assumes level_in is already synchronous to clk.
module hs_debounce #(
    parameter int   SAMPLES   = 6,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic run_n,
    input  logic tick,
    input  logic level_in,
    output logic level_q
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [CW-1:0] run_cnt_q;
    logic          state_q;

    // Count differing samples; commit the new level on the last one.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            state_q   <= RST_LEVEL;
            run_cnt_q <= '0;
        end else if (tick) begin
            if (level_in == state_q) begin
                run_cnt_q <= '0;
            end else if (run_cnt_q == LAST) begin
                state_q   <= level_in;
                run_cnt_q <= '0;
            end else begin
                run_cnt_q <= run_cnt_q + 1'b1;
            end
        end
    end

    assign level_q = state_q;

    // R2: the stable level never moves between ticks.
    a_r2_change_on_tick_only: assert property (@(posedge clk) disable iff (!run_n)
        !tick |=> $stable(state_q));
    // R2: the counter never exceeds the sample window.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!run_n)
        run_cnt_q < CW'(SAMPLES));
    // R9: reset holds the stable level at its reset value.
    a_r9_hold_in_reset: assert property (@(posedge clk)
        !run_n |=> (state_q == RST_LEVEL));
endmodule

// File: rtl/hs_csr.sv
// Control/status word: sticky event flags (W1C), LED and mask bits,
// capability header, registered read port.
// Assumes events are single-cycle pulses; a set beats a clear in one cycle.
module hs_csr
    import hs_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h4F
) (
    input  logic        clk,
    input  logic        run_n,
    input  logic        ins_evt,
    input  logic        rem_evt,
    input  logic        lane_wr,
    input  logic [7:0]  wbyte,
    input  logic        rd_en,
    output logic [31:0] rdata,
    output hs_ctl_t     ctl
);
    localparam logic [7:0] PTR_RD = NEXT_PTR & 8'hFC;

    hs_ctl_t     ctl_q;
    logic [31:0] rdata_q;
    logic [7:0]  ctl_byte;
    logic        unused_wbits;

    assign unused_wbits = ^{wbyte[5:4], wbyte[2], wbyte[0]};

    // Update sticky flags and software control bits.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            ctl_q <= '0;
        end else begin
            if (ins_evt) ctl_q.ins <= 1'b1;
            else if (lane_wr && wbyte[CTL_INS_BIT]) ctl_q.ins <= 1'b0;
            if (rem_evt) ctl_q.rem <= 1'b1;
            else if (lane_wr && wbyte[CTL_REM_BIT]) ctl_q.rem <= 1'b0;
            if (lane_wr) begin
                ctl_q.led <= wbyte[CTL_LED_BIT];
                ctl_q.msk <= wbyte[CTL_MSK_BIT];
            end
        end
    end

    // Assemble the visible control byte with reserved bits at zero.
    always_comb begin
        ctl_byte = '0;
        ctl_byte[CTL_INS_BIT] = ctl_q.ins;
        ctl_byte[CTL_REM_BIT] = ctl_q.rem;
        ctl_byte[CTL_LED_BIT] = ctl_q.led;
        ctl_byte[CTL_MSK_BIT] = ctl_q.msk;
    end

    // Capture the register word on a read request.
    always_ff @(posedge clk) begin
        if (!run_n) rdata_q <= '0;
        else if (rd_en) rdata_q <= {8'h00, ctl_byte, PTR_RD, HDR_ID};
    end

    assign rdata = rdata_q;
    assign ctl   = ctl_q;

    // R5: a pending insertion flag survives anything but a W1C.
    a_r5_ins_sticky: assert property (@(posedge clk) disable iff (!run_n)
        (ctl_q.ins && !(lane_wr && wbyte[CTL_INS_BIT])) |=> ctl_q.ins);
    // R5: a pending removal flag survives anything but a W1C.
    a_r5_rem_sticky: assert property (@(posedge clk) disable iff (!run_n)
        (ctl_q.rem && !(lane_wr && wbyte[CTL_REM_BIT])) |=> ctl_q.rem);
    // R8: fixed fields of every returned word.
    a_r8_fixed_fields: assert property (@(posedge clk) disable iff (!run_n)
        rd_en |=> (rdata_q[7:0] == 8'h06 && rdata_q[9:8] == 2'b00 &&
                   rdata_q[31:24] == 8'h00 && rdata_q[21:20] == 2'b00));
    // R10: read data holds without a request.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!run_n)
        !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/hotswap_ctrl.sv
// Hot swap insertion/extraction controller top.
// Assumes bus_rst_n and ms_tick are synchronous to clk; handle_sw is async.
module hotswap_ctrl
    import hs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         DEB_SAMPLES = 6,
    parameter logic [7:0] NEXT_PTR    = 8'h4F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst_n,
    input  logic        ms_tick,
    input  logic        handle_sw,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        enum_pull_n,
    output logic        led_pull_n
);
    logic    run_n;
    logic    sw_sync;
    logic    handle_open;
    logic    handle_prev_q;
    logic    ins_evt;
    logic    rem_evt;
    logic    lane_wr;
    hs_ctl_t ctl;
    logic    unused_inputs;

    assign run_n   = rst_n & bus_rst_n;
    assign lane_wr = reg_wr & reg_be[CTL_LANE];
    assign unused_inputs = ^{reg_be[3], reg_be[1:0], reg_wdata[31:24], reg_wdata[15:0]};

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (handle_sw),
        .q     (sw_sync)
    );

    hs_debounce #(.SAMPLES(DEB_SAMPLES), .RST_LEVEL(1'b1)) u_deb (
        .clk      (clk),
        .run_n    (run_n),
        .tick     (ms_tick),
        .level_in (sw_sync),
        .level_q  (handle_open)
    );

    // Remember the last debounced level for edge detection.
    always_ff @(posedge clk) begin
        if (!run_n) handle_prev_q <= 1'b1;
        else handle_prev_q <= handle_open;
    end

    assign ins_evt = handle_prev_q & ~handle_open;
    assign rem_evt = ~handle_prev_q & handle_open;

    hs_csr #(.NEXT_PTR(NEXT_PTR)) u_csr (
        .clk     (clk),
        .run_n   (run_n),
        .ins_evt (ins_evt),
        .rem_evt (rem_evt),
        .lane_wr (lane_wr),
        .wbyte   (reg_wdata[8*CTL_LANE +: 8]),
        .rd_en   (reg_rd),
        .rdata   (reg_rdata),
        .ctl     (ctl)
    );

    // Drive the open-drain outputs (0 = sink).
    assign enum_pull_n = ~((ctl.ins | ctl.rem) & ~ctl.msk);
    assign led_pull_n  = ~(ctl.led | ~bus_rst_n);

    // R3: a settled handle closure raises the insertion flag.
    a_r3_ins_on_close: assert property (@(posedge clk) disable iff (!run_n)
        $fell(handle_open) |=> ctl.ins);
    // R4: a settled handle opening raises the removal flag.
    a_r4_rem_on_open: assert property (@(posedge clk) disable iff (!run_n)
        $rose(handle_open) |=> ctl.rem);
    // R6: mask keeps the interrupt released.
    a_r6_mask_releases: assert property (@(posedge clk) disable iff (!run_n)
        ctl.msk |-> enum_pull_n);
    // R7: bus reset lights the LED.
    a_r7_led_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> !led_pull_n);
endmodule

// File: tb/hotswap_ctrl_tb_top.sv
module hotswap_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        handle_sw = 1'b1;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        enum_pull_n;
    logic        led_pull_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic        rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    hotswap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ms_tick(ms_tick),
        .handle_sw(handle_sw), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .enum_pull_n(enum_pull_n), .led_pull_n(led_pull_n)
    );

    function automatic logic [31:0] word(input logic [7:0] c);
        return {8'h00, c, 8'h4C, 8'h06};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard one cycle after each read request.
    always @(posedge clk) rd_d <= reg_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: actual %h expected none", reg_rdata);
            end else begin
                chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sw(input logic v);
        handle_sw = v;
        cyc(4);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; cyc(1); ms_tick = 1'b0; cyc(3);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0; reg_be = 4'h0;
        cyc(1);
    endtask

    // Driver: push expected word, then issue the read.
    task automatic rd(input logic [7:0] c, input string req);
        exp_q.push_back(word(c));
        tag_q.push_back(req);
        reg_rd = 1'b1; cyc(1); reg_rd = 1'b0; cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cyc(4);
        chk("R7 led in reset", {31'd0, led_pull_n}, 32'd0);
        rst_n = 1'b1; bus_rst_n = 1'b1;
        cyc(2);
        chk("R1 enum idle", {31'd0, enum_pull_n}, 32'd1);
        rd(8'h00, "R1 reset word");
        // R2: five differing samples then a bounce back
        set_sw(1'b0); ticks(5);
        set_sw(1'b1); ticks(1);
        chk("R2 bounce no event", {31'd0, enum_pull_n}, 32'd1);
        rd(8'h00, "R2 bounce word");
        set_sw(1'b0); ticks(5);
        chk("R2 five ticks not enough", {31'd0, enum_pull_n}, 32'd1);
        ticks(1);
        chk("R3 enum on insert", {31'd0, enum_pull_n}, 32'd0);
        rd(8'h80, "R3 insert flag");
        // R5: writes that must not clear
        wr(4'b1011, 32'hFFFF_FFFF);
        rd(8'h80, "R5 lane off no clear / R8 other lanes");
        wr(4'b0100, 32'h0000_0000);
        chk("R5 write zero keeps enum", {31'd0, enum_pull_n}, 32'd0);
        // R6 mask, R8 reserved bits
        wr(4'b0100, 32'h0037_0000);
        chk("R6 masked enum", {31'd0, enum_pull_n}, 32'd1);
        rd(8'h82, "R8 reserved bits zero");
        wr(4'b0100, 32'h0000_0000);
        chk("R6 unmask enum", {31'd0, enum_pull_n}, 32'd0);
        wr(4'b0100, 32'h0080_0000);
        chk("R5 clear releases enum", {31'd0, enum_pull_n}, 32'd1);
        // R4 removal, then insertion again
        set_sw(1'b1); ticks(6);
        chk("R4 enum on removal", {31'd0, enum_pull_n}, 32'd0);
        rd(8'h40, "R4 removal flag");
        set_sw(1'b0); ticks(6);
        rd(8'hC0, "R3 both flags");
        wr(4'b0100, 32'h0040_0000);
        chk("R5 one flag left", {31'd0, enum_pull_n}, 32'd0);
        rd(8'h80, "R5 partial clear");
        wr(4'b0100, 32'h0080_0000);
        chk("R5 all clear", {31'd0, enum_pull_n}, 32'd1);
        // R7 LED, R10 hold
        wr(4'b0100, 32'h0008_0000);
        chk("R7 led on", {31'd0, led_pull_n}, 32'd0);
        chk("R10 rdata held", reg_rdata, word(8'h80));
        rd(8'h08, "R7 led bit");
        wr(4'b0100, 32'h0000_0000);
        chk("R7 led off", {31'd0, led_pull_n}, 32'd1);
        // R9 bus reset with handle closed
        bus_rst_n = 1'b0; cyc(3);
        chk("R7 led forced by bus reset", {31'd0, led_pull_n}, 32'd0);
        bus_rst_n = 1'b1; cyc(2);
        chk("R9 no event yet", {31'd0, enum_pull_n}, 32'd1);
        rd(8'h00, "R9 cleared by bus reset");
        ticks(6);
        chk("R9 insert after bus reset", {31'd0, enum_pull_n}, 32'd0);
        rd(8'h80, "R9 insert flag");
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule